// File: doc/BRIEF.md
# Write-Miss Invalidation Sequencer

This block models the coherence-controller side of a write miss to a cache block that other caches also hold. When a write miss is handed over, the sequencer first spends a fixed number of cycles gaining ownership of the block. It then sends one invalidate to each sharer, one at a time and a fixed gap apart. Each invalidate is acknowledged explicitly a fixed latency after it was sent. Because the invalidates are in flight together, only the last acknowledgement decides when the write is complete.

A mode input selects when the writing processor may continue. In the strict mode, which keeps sequential consistency, the stall is held until every acknowledgement has come back. In the relaxed mode, the stall ends as soon as ownership is held, and the invalidates finish in the background. Either way, a one-cycle done pulse marks the return of the last acknowledgement. The sequencer handles one miss at a time and holds its ready output low while busy.

In what follows, "cycle t" means the value the outputs hold just after the t-th rising clock edge that follows the edge on which a request was accepted. Defaults: 4 sharers, ownership 50 cycles, issue gap 10 cycles, acknowledgement latency 80 cycles.

Top module: `inval_seq`

## Requirements
- R1: After reset, ready_o is 1 and stall_o, inv_valid_o and done_o are all 0. Reset is synchronous and active low, and it abandons any miss in progress.
- R2: A request is accepted on a rising edge where req_i and ready_o are both 1. From cycle 1 onward, ready_o is 0 until the done cycle. Requests that arrive while busy are ignored and are not stored. Changes on sharers_i or mode_sc_i after acceptance have no effect on the miss in progress.
- R3: Ownership is obtained at cycle OWN_CYC (50).
- R4: Each set bit of sharers_i (bit i = sharer i) gets exactly one invalidate. Invalidates go out in ascending index order, and zero bits are skipped. The k-th invalidate (k = 1, 2, ...) appears as a one-cycle inv_valid_o pulse at cycle OWN_CYC + ISSUE_GAP*k, with inv_idx_o holding the sharer index.
- R5: Each invalidate is acknowledged ACK_LAT (80) cycles after it is issued. With n sharers (n > 0), done_o pulses at cycle OWN_CYC + ISSUE_GAP*n + ACK_LAT. For four sharers this is cycle 170.
- R6: With mode_sc_i = 1 (strict) at acceptance, stall_o is 1 from cycle 1 and falls in the done cycle.
- R7: With mode_sc_i = 0 (relaxed) at acceptance, stall_o is 1 from cycle 1 and falls at cycle OWN_CYC. Invalidates and done still follow R4 and R5.
- R8: With an all-zero sharer vector, no invalidate is sent and done_o pulses at cycle OWN_CYC in both modes.
- R9: done_o is high for exactly one cycle per miss, and ready_o returns to 1 in that same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| req_i | input | 1 | Write-miss request |
| sharers_i | input | N_SHR | Sharer vector sampled at acceptance, bit i = sharer i |
| mode_sc_i | input | 1 | 1 = strict (stall to last acknowledgement), 0 = relaxed |
| ready_o | output | 1 | High when a request can be accepted |
| stall_o | output | 1 | Writer stall |
| inv_valid_o | output | 1 | One-cycle invalidate pulse |
| inv_idx_o | output | IDX_W | Target sharer of the invalidate |
| done_o | output | 1 | One-cycle pulse when the last acknowledgement returns |

## Verification
The sequencer is run with a full sharer vector, an empty one, a single sharer, and sparse patterns whose set bits have gaps between them. Each pattern is run in both modes. The full vector checks the 170-cycle total and the overlap of acknowledgements. The empty vector separates completion at the ownership point from the normal path. Sparse patterns show that zero bits are skipped and that the done time depends on the number of sharers, not on their highest index. Running each pattern in both modes shows where stall_o is released while done_o and the invalidate timing stay the same. Directed runs cover requests during a busy phase, input changes after acceptance, and reset in the middle of a miss.

// File: rtl/inval_pkg.sv
// Package: shared state type for the invalidation sequencer.
// Assumes nothing beyond SystemVerilog 2017 enum support.
package inval_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,   // waiting for a write miss
        ST_OWN   = 2'd1,   // counting down the ownership latency
        ST_ISSUE = 2'd2,   // sending invalidates one per gap
        ST_DRAIN = 2'd3    // all sent, waiting for the last acknowledgement
    } seq_state_t;

endpackage

// File: rtl/inval_pick.sv
// Module: lowest-index selector.
// Returns the lowest set bit of a vector as a one-hot grant and as an index.
// Assumes N >= 2. The result is only meaningful while any_o is high.
module inval_pick #(
    parameter int N     = 4,
    parameter int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]     vec_i,
    output logic             any_o,
    output logic [N-1:0]     grant_o,
    output logic [IDX_W-1:0] idx_o
);

    // Scan from the top down so that the lowest set bit wins last.
    always_comb begin
        idx_o   = '0;
        grant_o = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec_i[i]) begin
                idx_o   = IDX_W'(i);
                grant_o = N'(1) << i;
            end
        end
        any_o = |vec_i;
    end

endmodule

// File: rtl/inval_ack_model.sv
// Module: acknowledgement latency model.
// There is one delay slot per sharer. A slot is armed when an invalidate is sent
// to its sharer and raises a one-cycle acknowledgement so that the controller
// consumes it ACK_LAT cycles after the issue edge.
// Assumes ACK_LAT >= 2 and at most one arm per slot per miss.
module inval_ack_model #(
    parameter int N       = 4,
    parameter int ACK_LAT = 80,
    parameter int IDX_W   = (N > 1) ? $clog2(N) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fire_i,
    input  logic [IDX_W-1:0] fire_idx_i,
    output logic [N-1:0]     ack_o
);

    localparam int CW = (ACK_LAT > 2) ? $clog2(ACK_LAT) : 1;
    // The slot counts down to zero, then the registered pulse adds one cycle
    // and the controller adds one more, which gives ACK_LAT in total.
    localparam logic [CW-1:0] LOAD = CW'(ACK_LAT - 2);

    generate
        for (genvar g = 0; g < N; g++) begin : g_slot
            logic          act_q;
            logic [CW-1:0] cnt_q;
            logic          ack_q;

            // One slot: arm on issue, count down, then pulse the acknowledgement.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    act_q <= 1'b0;
                    cnt_q <= '0;
                    ack_q <= 1'b0;
                end else begin
                    ack_q <= 1'b0;
                    if (fire_i && fire_idx_i == IDX_W'(g)) begin
                        act_q <= 1'b1;
                        cnt_q <= LOAD;
                    end else if (act_q) begin
                        if (cnt_q == '0) begin
                            act_q <= 1'b0;
                            ack_q <= 1'b1;
                        end else begin
                            cnt_q <= cnt_q - 1'b1;
                        end
                    end
                end
            end

            assign ack_o[g] = ack_q;
        end
    endgenerate

    // R5: the issue gap keeps acknowledgements apart, so at most one arrives per cycle.
    a_r5_single_ack: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ack_o));

endmodule

// File: rtl/inval_ctrl.sv
// Module: invalidation sequencing controller.
// Latches the sharer vector and mode on acceptance, counts the ownership
// latency, sends invalidates one per gap in ascending order, and counts the
// outstanding acknowledgements until none are left.
// Assumes acknowledgements arrive at most one per cycle and only for issued targets.
module inval_ctrl
    import inval_pkg::*;
#(
    parameter int N         = 4,
    parameter int OWN_CYC   = 50,
    parameter int ISSUE_GAP = 10,
    parameter int IDX_W     = (N > 1) ? $clog2(N) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_i,
    input  logic [N-1:0]     sharers_i,
    input  logic             mode_sc_i,
    input  logic             pick_any_i,
    input  logic [N-1:0]     pick_grant_i,
    input  logic [IDX_W-1:0] pick_idx_i,
    input  logic             ack_any_i,
    output logic [N-1:0]     pending_o,
    output logic             fire_o,
    output logic [IDX_W-1:0] fire_idx_o,
    output logic             ready_o,
    output logic             stall_o,
    output logic             inv_valid_o,
    output logic [IDX_W-1:0] inv_idx_o,
    output logic             done_o
);

    localparam int TMAX = (OWN_CYC > ISSUE_GAP) ? OWN_CYC : ISSUE_GAP;
    localparam int TW   = $clog2(TMAX + 1);
    localparam int OW   = $clog2(N + 1);
    localparam logic [TW-1:0] OWN_LAST = TW'(OWN_CYC - 1);
    localparam logic [TW-1:0] GAP_LAST = TW'(ISSUE_GAP - 1);

    seq_state_t    state_q;
    logic [TW-1:0] timer_q;
    logic [N-1:0]  pending_q;
    logic          mode_q;
    logic [OW-1:0] outst_q;
    logic [N-1:0]  pending_left;

    assign pending_o    = pending_q;
    // Fire when the issue gap has elapsed; the pick module supplies the target.
    assign fire_o       = (state_q == ST_ISSUE) && (timer_q == GAP_LAST) && pick_any_i;
    assign fire_idx_o   = pick_idx_i;
    assign pending_left = pending_q & ~pick_grant_i;

    // Sequencer state, timers, outstanding count and registered outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= ST_IDLE;
            timer_q     <= '0;
            pending_q   <= '0;
            mode_q      <= 1'b0;
            outst_q     <= '0;
            ready_o     <= 1'b1;
            stall_o     <= 1'b0;
            inv_valid_o <= 1'b0;
            inv_idx_o   <= '0;
            done_o      <= 1'b0;
        end else begin
            inv_valid_o <= 1'b0;
            done_o      <= 1'b0;
            outst_q     <= outst_q + OW'(fire_o) - OW'(ack_any_i);
            case (state_q)
                ST_IDLE: begin
                    if (req_i) begin
                        pending_q <= sharers_i;
                        mode_q    <= mode_sc_i;
                        timer_q   <= '0;
                        stall_o   <= 1'b1;
                        ready_o   <= 1'b0;
                        state_q   <= ST_OWN;
                    end
                end
                ST_OWN: begin
                    if (timer_q == OWN_LAST) begin
                        timer_q <= '0;
                        if (pending_q == '0) begin
                            done_o  <= 1'b1;
                            ready_o <= 1'b1;
                            stall_o <= 1'b0;
                            state_q <= ST_IDLE;
                        end else begin
                            stall_o <= mode_q;
                            state_q <= ST_ISSUE;
                        end
                    end else begin
                        timer_q <= timer_q + 1'b1;
                    end
                end
                ST_ISSUE: begin
                    if (fire_o) begin
                        inv_valid_o <= 1'b1;
                        inv_idx_o   <= pick_idx_i;
                        pending_q   <= pending_left;
                        timer_q     <= '0;
                        if (pending_left == '0) state_q <= ST_DRAIN;
                    end else begin
                        timer_q <= timer_q + 1'b1;
                    end
                end
                ST_DRAIN: begin
                    if (ack_any_i && outst_q == OW'(1)) begin
                        done_o  <= 1'b1;
                        ready_o <= 1'b1;
                        stall_o <= 1'b0;
                        state_q <= ST_IDLE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // R5: an acknowledgement only arrives while an invalidate is outstanding.
    a_r5_ack_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
        ack_any_i |-> (outst_q != '0));
    // R9: done lasts a single cycle.
    a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    // R6: strict mode keeps the writer stalled for the whole busy period.
    a_r6_sc_stall_held: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE && mode_q && !$rose(state_q == ST_OWN)) |-> stall_o);
    // R7: relaxed mode has released the writer once the invalidate phase begins.
    a_r7_relaxed_free: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_ISSUE || state_q == ST_DRAIN) && !mode_q) |-> !stall_o);
    // R4: each issued target is a pending sharer, and the grant is one-hot.
    a_r4_target_pending: assert property (@(posedge clk) disable iff (!rst_n)
        fire_o |-> ((pending_q & pick_grant_i) != '0) && $onehot0(pick_grant_i));
    // R2: no request is accepted while a miss is in progress.
    a_r2_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE) |-> !ready_o);

endmodule

// File: rtl/inval_seq.sv
// Module: write-miss invalidation sequencer (top).
// Connects the controller, the lowest-index selector and the acknowledgement
// latency model. Assumes N_SHR >= 2, ACK_LAT >= 2, OWN_CYC >= 1, ISSUE_GAP >= 1.
module inval_seq #(
    parameter int N_SHR     = 4,
    parameter int OWN_CYC   = 50,
    parameter int ISSUE_GAP = 10,
    parameter int ACK_LAT   = 80,
    parameter int IDX_W     = (N_SHR > 1) ? $clog2(N_SHR) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_i,
    input  logic [N_SHR-1:0] sharers_i,
    input  logic             mode_sc_i,
    output logic             ready_o,
    output logic             stall_o,
    output logic             inv_valid_o,
    output logic [IDX_W-1:0] inv_idx_o,
    output logic             done_o
);

    logic [N_SHR-1:0] pending;
    logic [N_SHR-1:0] grant;
    logic [N_SHR-1:0] ack_vec;
    logic [IDX_W-1:0] pick_idx;
    logic [IDX_W-1:0] fire_idx;
    logic             pick_any;
    logic             fire;

    inval_pick #(.N(N_SHR), .IDX_W(IDX_W)) u_pick (
        .vec_i   (pending),
        .any_o   (pick_any),
        .grant_o (grant),
        .idx_o   (pick_idx)
    );

    inval_ack_model #(.N(N_SHR), .ACK_LAT(ACK_LAT), .IDX_W(IDX_W)) u_ack (
        .clk        (clk),
        .rst_n      (rst_n),
        .fire_i     (fire),
        .fire_idx_i (fire_idx),
        .ack_o      (ack_vec)
    );

    inval_ctrl #(.N(N_SHR), .OWN_CYC(OWN_CYC), .ISSUE_GAP(ISSUE_GAP), .IDX_W(IDX_W)) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_i        (req_i),
        .sharers_i    (sharers_i),
        .mode_sc_i    (mode_sc_i),
        .pick_any_i   (pick_any),
        .pick_grant_i (grant),
        .pick_idx_i   (pick_idx),
        .ack_any_i    (|ack_vec),
        .pending_o    (pending),
        .fire_o       (fire),
        .fire_idx_o   (fire_idx),
        .ready_o      (ready_o),
        .stall_o      (stall_o),
        .inv_valid_o  (inv_valid_o),
        .inv_idx_o    (inv_idx_o),
        .done_o       (done_o)
    );

endmodule

// File: tb/tb_inval_seq.sv
module tb_inval_seq;

    localparam int N = 4;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         req = 1'b0;
    logic [N-1:0] sharers = '0;
    logic         mode_sc = 1'b0;
    logic         ready, stall, inv_valid, done;
    logic [1:0]   inv_idx;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;   // 125 MHz

    inval_seq dut (
        .clk(clk), .rst_n(rst_n), .req_i(req), .sharers_i(sharers),
        .mode_sc_i(mode_sc), .ready_o(ready), .stall_o(stall),
        .inv_valid_o(inv_valid), .inv_idx_o(inv_idx), .done_o(done)
    );

    typedef struct packed {
        logic [3:0] sh;
        logic       sc;
        logic [7:0] stall_t;
        logic [7:0] done_t;
        logic [7:0] ninv;
    } vec_t;

    // Expected values are written by hand from R3..R8: 50 + 10*n + 80.
    localparam vec_t VEC [8] = '{
        '{4'b1111, 1'b1, 8'd170, 8'd170, 8'd4},
        '{4'b1111, 1'b0, 8'd50,  8'd170, 8'd4},
        '{4'b0000, 1'b1, 8'd50,  8'd50,  8'd0},
        '{4'b0000, 1'b0, 8'd50,  8'd50,  8'd0},
        '{4'b0100, 1'b1, 8'd140, 8'd140, 8'd1},
        '{4'b1010, 1'b0, 8'd50,  8'd150, 8'd2},
        '{4'b1001, 1'b1, 8'd150, 8'd150, 8'd2},
        '{4'b0111, 1'b0, 8'd50,  8'd160, 8'd3}
    };

    task automatic check(input bit ok, input string req_tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req_tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    // k-th (1-based) set bit of a vector, scanning from bit 0 upward.
    function automatic int nth_set(input logic [N-1:0] v, input int k);
        int c = 0;
        for (int i = 0; i < N; i++) begin
            if (v[i]) begin
                c++;
                if (c == k) return i;
            end
        end
        return -1;
    endfunction

    // Accept one miss, scramble the inputs after acceptance (R2), then observe.
    task automatic run_vec(input vec_t v);
        int  stall_fall = -1, done_t = -1, done_cnt = 0, ninv = 0;
        bit  order_ok = 1, ready_ok = 1;
        req = 1'b1; sharers = v.sh; mode_sc = v.sc;
        @(posedge clk); #1;
        req = 1'b0; sharers = ~v.sh; mode_sc = ~v.sc;
        for (int t = 1; t <= 200; t++) begin
            @(posedge clk); #1;
            if (!stall && stall_fall < 0) stall_fall = t;
            if (inv_valid) begin
                ninv++;
                if (t != 50 + 10 * ninv || int'(inv_idx) != nth_set(v.sh, ninv)) order_ok = 0;
            end
            if (done) begin done_cnt++; if (done_t < 0) done_t = t; end
            if (done_t < 0 && ready) ready_ok = 0;
            if (t == int'(v.done_t) && !ready) ready_ok = 0;
        end
        check(stall_fall == int'(v.stall_t), v.sc ? "R6 stall release" : "R7 stall release",
              stall_fall, v.stall_t);
        check(done_t == int'(v.done_t) && done_cnt == 1,
              (v.sh == 0) ? "R8 done time" : "R5 done time", done_t, v.done_t);
        check(ninv == int'(v.ninv) && order_ok, "R4 invalidate count/order", ninv, v.ninv);
        check(ready_ok, "R9 R2 ready", ready_ok, 1);
    endtask

    initial begin
        #(8 * 150000);
        fails++; checks++;
        $display("FAIL watchdog expired actual=running expected=finished");
        summary();
    end

    initial begin
        int busy_hits;
        int t_done;
        repeat (3) @(posedge clk);
        #1;
        // R1: reset state
        check(ready && !stall && !inv_valid && !done, "R1 reset state",
              {ready, stall, inv_valid, done}, 4'b1000);
        rst_n = 1'b1;
        @(posedge clk); #1;

        // Table walk: R2..R9 across patterns and modes.
        foreach (VEC[i]) begin
            run_vec(VEC[i]);
        end

        // R2: requests while busy are ignored and not stored.
        req = 1'b1; sharers = 4'b1111; mode_sc = 1'b1;
        @(posedge clk); #1;
        req = 1'b0;
        busy_hits = 0;
        t_done = -1;
        for (int t = 1; t <= 300; t++) begin
            if (t == 20 || t == 100) req = 1'b1;
            @(posedge clk); #1;
            req = 1'b0;
            if (done && t_done < 0) t_done = t;
            if (t_done > 0 && t > t_done && (stall || inv_valid || !ready)) busy_hits++;
        end
        check(t_done == 170, "R2 busy request done time", t_done, 170);
        check(busy_hits == 0, "R2 busy request not stored", busy_hits, 0);

        // R1: reset in the middle of a miss abandons it.
        req = 1'b1; sharers = 4'b1111; mode_sc = 1'b1;
        @(posedge clk); #1;
        req = 1'b0;
        repeat (99) @(posedge clk);
        #1;
        rst_n = 1'b0;
        @(posedge clk); #1;
        check(ready && !stall && !inv_valid && !done, "R1 reset mid-run",
              {ready, stall, inv_valid, done}, 4'b1000);
        rst_n = 1'b1;
        busy_hits = 0;
        for (int t = 0; t < 120; t++) begin
            @(posedge clk); #1;
            if (inv_valid || done || stall) busy_hits++;
        end
        check(busy_hits == 0, "R1 no leftover activity after reset", busy_hits, 0);

        // R8 / R3: recovery with an empty vector in strict mode.
        run_vec('{4'b0000, 1'b1, 8'd50, 8'd50, 8'd0});
        // R3 R7: single high sharer in relaxed mode, ownership then first issue.
        run_vec('{4'b1000, 1'b0, 8'd50, 8'd140, 8'd1});

        summary();
    end

endmodule